// File: doc/BRIEF.md
# Loop Control Token Generator

This block paces an iterative loop. It holds one count token in a small ring made of a counter, a comparator against a programmed limit, and a single token stage. While the count is below the limit it offers an iteration token, which an input selector in the loop body uses to admit one more pass. When the count reaches the limit it offers a completion token, which an output selector uses to release the loop result. After the completion token is taken, the count returns to zero and the sequence starts again, with no end.

Each token is offered on a valid/ready pair. A token stays offered until it is accepted. Only one token exists at a time, so the two outputs are never offered together. The counter is built from 8-bit adder slices with a rippled carry. At the default width of 16 bits, two slices are chained, which allows loop counts well above 255, such as 768.

Top module: `loopCtlGen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, neither iterValid nor doneValid is high. In the next cycle iterValid is high if loopLimit is non-zero, and doneValid is high if loopLimit is zero.
- R2: With a non-zero loopLimit N held steady, exactly N iteration handshakes occur between two consecutive completion handshakes, and also before the first completion handshake.
- R3: With loopLimit zero, only completion handshakes occur and iterValid never rises.
- R4: An offered token (iterValid or doneValid high with its ready low) is still offered in the next cycle. The two valids are never high together.
- R5: After a completion handshake with N non-zero, the next token offered is an iteration token. The sequence repeats indefinitely.
- R6: The counter is formed from chained 8-bit adder slices, the low slice's carry feeding the next. A loopLimit of 768, or of 256, yields that many iteration tokens per completion token.
- R7: Under random backpressure on both ready inputs, no token is lost or duplicated. The counts of R2 still hold.
- R8: In the cycle after any handshake, neither valid is high, because the token re-enters the comparator stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loopLimit | input | CNT_W | Programmed iteration count (held constant during operation) |
| iterValid | output | 1 | Iteration token offered |
| iterReady | input | 1 | Iteration token accepted by the loop entry |
| doneValid | output | 1 | Completion token offered |
| doneReady | input | 1 | Completion token accepted by the loop exit |

## Verification
The assertions take for granted that loopLimit does not change while the ring is running. They also assume that the ready inputs are free to go high or low in any cycle. The stimulus changes loopLimit only while reset is held, and re-releases reset after each change. It drives both readies from a seeded random source at several acceptance rates, with directed runs at the limits 0, 1, 255, 256 and 768.

// File: rtl/loopCtlPkg.sv
package loopCtlPkg;
  localparam int SLICE_W = 8;

  typedef struct packed {
    logic inc;
    logic clr;
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_EVAL  = 2'd0,
    ST_ITER  = 2'd1,
    ST_DONE  = 2'd2
  } ringState_t;
endpackage

// File: rtl/lcgSliceAdder.sv
module lcgSliceAdder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] full;
  always_comb begin
    full = {1'b0, a} + {{W{1'b0}}, cin};
    sum  = full[W-1:0];
    cout = full[W];
  end
endmodule

// File: rtl/lcgDatapath.sv
module lcgDatapath
  import loopCtlPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] loopLimit,
  input  ctlStrobe_t       strobes,
  output logic             cntBelow,
  output logic [CNT_W-1:0] cnt
);
  localparam int NSLICE = CNT_W / SLICE_W;

  logic [NSLICE:0]     carry;
  logic [CNT_W-1:0]    incSum;

  assign carry[0] = 1'b1;

  for (genvar s = 0; s < NSLICE; s++) begin : gSlice
    lcgSliceAdder #(.W(SLICE_W)) uAdd (
      .a    (cnt[s*SLICE_W +: SLICE_W]),
      .cin  (carry[s]),
      .sum  (incSum[s*SLICE_W +: SLICE_W]),
      .cout (carry[s+1])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (strobes.clr) cnt <= '0;
    else if (strobes.inc) cnt <= incSum;
  end

  assign cntBelow = (cnt < loopLimit);

  // R6
  ripple_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.inc && !strobes.clr |=> cnt == $past(cnt) + 1'b1);

  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clr |=> cnt == '0);
endmodule

// File: rtl/lcgControl.sv
module lcgControl
  import loopCtlPkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cntBelow,
  input  logic       iterReady,
  input  logic       doneReady,
  output logic       iterValid,
  output logic       doneValid,
  output ctlStrobe_t strobes
);
  ringState_t state, stateNext;

  always_comb begin
    stateNext   = state;
    strobes.inc = 1'b0;
    strobes.clr = 1'b0;
    unique case (state)
      ST_EVAL: stateNext = cntBelow ? ST_ITER : ST_DONE;
      ST_ITER: if (iterReady) begin
        strobes.inc = 1'b1;
        stateNext   = ST_EVAL;
      end
      ST_DONE: if (doneReady) begin
        strobes.clr = 1'b1;
        stateNext   = ST_EVAL;
      end
      default: stateNext = ST_EVAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_EVAL;
    else        state <= stateNext;
  end

  assign iterValid = (state == ST_ITER);
  assign doneValid = (state == ST_DONE);

  // R4
  iter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iterValid && !iterReady |=> iterValid);

  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid && !doneReady |=> doneValid);

  // R4
  one_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({iterValid, doneValid}));

  // R8
  reeval_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iterValid && iterReady) || (doneValid && doneReady) |=> !iterValid && !doneValid);
endmodule

// File: rtl/loopCtlGen.sv
module loopCtlGen
  import loopCtlPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] loopLimit,
  output logic             iterValid,
  input  logic             iterReady,
  output logic             doneValid,
  input  logic             doneReady
);
  ctlStrobe_t       strobes;
  logic             cntBelow;
  logic [CNT_W-1:0] cnt;

  initial begin
    width_multiple_chk: assert (CNT_W % SLICE_W == 0 && CNT_W >= SLICE_W);
  end

  lcgDatapath #(.CNT_W(CNT_W)) uPath (
    .clk       (clk),
    .rst_n     (rst_n),
    .loopLimit (loopLimit),
    .strobes   (strobes),
    .cntBelow  (cntBelow),
    .cnt       (cnt)
  );

  lcgControl uCtl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cntBelow  (cntBelow),
    .iterReady (iterReady),
    .doneReady (doneReady),
    .iterValid (iterValid),
    .doneValid (doneValid),
    .strobes   (strobes)
  );

  // R2
  limit_reached_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid && $stable(loopLimit) |-> cnt >= loopLimit);

  // R3
  zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loopLimit == '0 && $stable(loopLimit) |-> !iterValid);
endmodule

// File: tb/tb_loopCtlGen.sv
`timescale 1ns/1ps
module tb_loopCtlGen;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] loopLimit = '0;
  logic             iterValid, doneValid;
  logic             iterReady = 1'b0, doneReady = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  loopCtlGen #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .loopLimit(loopLimit),
    .iterValid(iterValid), .iterReady(iterReady),
    .doneValid(doneValid), .doneReady(doneReady)
  );

  function automatic bit rollReady(int pct);
    return ($urandom % 100) < pct;
  endfunction

  function automatic string countTag(int n);
    return (n > 255) ? "R6" : "R2";
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic runCase(int n, int nDone, int pct);
    int  iters = 0;
    int  dones = 0;
    bit  prevIv = 0, prevDv = 0, prevIr = 0, prevDr = 0;
    bit  afterDone = 0;
    bit  hsI, hsD;
    @(posedge clk); #1;
    rst_n = 1'b0; iterReady = 1'b0; doneReady = 1'b0;
    loopLimit = CNT_W'(n);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!iterValid && !doneValid, "R1", "valid under reset", {iterValid, doneValid}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(!iterValid && !doneValid, "R1", "valid first cycle", {iterValid, doneValid}, 0);
    @(posedge clk); #1;
    @(negedge clk);
    check(iterValid == (n != 0) && doneValid == (n == 0), "R1", "first token",
          {iterValid, doneValid}, (n != 0) ? 2 : 1);
    while (dones < nDone) begin
      @(posedge clk); #1;
      iterReady = rollReady(pct);
      doneReady = rollReady(pct);
      @(negedge clk);
      check(!(iterValid && doneValid), "R4", "both valid", {iterValid, doneValid}, 0);
      if (prevIv && !prevIr)
        check(iterValid, "R4", "iter token dropped", iterValid, 1);
      if (prevDv && !prevDr)
        check(doneValid, "R4", "done token dropped", doneValid, 1);
      if ((prevIv && prevIr) || (prevDv && prevDr))
        check(!iterValid && !doneValid, "R8", "no gap after handshake",
              {iterValid, doneValid}, 0);
      if (n == 0)
        check(!iterValid, "R3", "iter with zero limit", iterValid, 0);
      if (afterDone && (iterValid || doneValid)) begin
        if (n != 0) check(iterValid, "R5", "token after restart", iterValid, 1);
        afterDone = 0;
      end
      hsI = iterValid && iterReady;
      hsD = doneValid && doneReady;
      if (hsI) begin
        check(iters < n, (pct < 100) ? "R7" : countTag(n), "extra iter", iters + 1, n);
        iters++;
      end
      if (hsD) begin
        check(iters == n, (n == 0) ? "R3" : countTag(n), "iters per done", iters, n);
        iters = 0;
        dones++;
        afterDone = 1;
      end
      prevIv = iterValid; prevDv = doneValid;
      prevIr = iterReady; prevDr = doneReady;
    end
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    runCase(10,  4, 60);
    runCase(10,  3, 30);
    runCase(0,   5, 50);
    runCase(1,   6, 40);
    runCase(255, 2, 100);
    runCase(256, 2, 100);
    runCase(768, 2, 100);
    runCase(768, 1, 70);
    runCase(37,  3, 20);
    summary();
    $finish;
  end

  initial begin
    #(5 * 150000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end
endmodule